// File: doc/BRIEF.md
# Tone-Presence Guard Timer

This block is the digital stand-in for the resistor-capacitor steering network that follows a tone-pair detector in a touch-tone receiver. Its input `est` is high while the detector reports a valid tone pair. A 4-bit decoded key code arrives with it. The block counts clock cycles to confirm the tone. A digit is accepted only after `est` has stayed high for a programmable number of cycles. The pause that follows is accepted only after `est` has stayed low for a second programmable number of cycles. Any shorter burst is filtered out, and so is any shorter drop-out.

When a digit is accepted, the code is latched into a receive register. After a fixed settling delay, `digit_valid` rises and `rx_full` pulses for exactly one clock. `digit_valid` falls again once the pause has been confirmed. The receive register keeps the last accepted code until the next digit replaces it. While call-progress mode is selected, the block accepts nothing.

The guard inputs are given in clock cycles. For example, a 40 ms acceptance time and a 40 ms minimum pause at the system clock rate become cycle counts. Both guards are expected to be at least `SETTLE+1`, and no smaller than 2.

Top module: `tone_guard_timer`

## Requirements
- R1: During and after reset, `rx_code` is 0, `digit_valid` is 0 and `rx_full` is 0.
- R2: When `est` is sampled high on `present_guard` consecutive rising edges, the digit is registered. `rx_code` takes the value of `code_in` sampled at the last of those edges and shows it from that edge onward.
- R3: A high burst on `est` that is sampled on fewer than `present_guard` consecutive edges leaves `rx_code`, `digit_valid` and `rx_full` unchanged.
- R4: While a registered digit has not yet been released by a confirmed pause, changes on `code_in` are ignored and `rx_code` holds.
- R5: `digit_valid` rises `SETTLE` edges after the registering edge. At that same edge `rx_full` goes high for exactly one cycle, once per registered digit.
- R6: After a digit is registered, `digit_valid` falls at the edge where `est` has been sampled low on `absent_guard` consecutive edges. `rx_code` keeps the digit.
- R7: A drop-out of `est` sampled low on fewer than `absent_guard` consecutive edges is ignored. There is no second registration, no extra `rx_full` pulse, `rx_code` is unchanged and `digit_valid` stays high.
- R8: While `cp_mode` is high, no digit is registered and `rx_code` holds. From the next edge, `digit_valid` is 0 and any pending `rx_full` pulse is cancelled. A new digit then needs a full `present_guard` run after `cp_mode` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_mode | input | 1 | Call-progress mode; blocks digit acceptance |
| est | input | 1 | Early steering from the tone detector |
| code_in | input | 4 | Decoded key code from the detector |
| present_guard | input | CNT_W | Tone-present guard in clock cycles |
| absent_guard | input | CNT_W | Tone-absent guard in clock cycles |
| rx_code | output | 4 | Receive register holding the last accepted code |
| digit_valid | output | 1 | Delayed steering: high from settle until pause confirmed |
| rx_full | output | 1 | One-cycle strobe per accepted digit |

## Verification
`rx_code` changes on the registering edge itself. `digit_valid` and `rx_full` follow `SETTLE` edges later. The fall of `digit_valid` lands on the edge that completes the `absent_guard`-long low run, and a `cp_mode` clear is seen one edge after it is raised. The bench drives inputs on falling edges and keeps a cycle model that counts run lengths of `est` at each rising edge. It schedules the settle edge from the registering edge and compares all three outputs at every falling edge. Directed checks sample at the end of each stimulus phase, when every due transition has landed.

// File: rtl/tone_guard_timer.sv
module tone_guard_timer #(
  parameter int CNT_W  = 24,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cp_mode,
  input  logic             est,
  input  logic [3:0]       code_in,
  input  logic [CNT_W-1:0] present_guard,
  input  logic [CNT_W-1:0] absent_guard,
  output logic [3:0]       rx_code,
  output logic             digit_valid,
  output logic             rx_full
);
  localparam int SW = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {IDLE, QUAL_PRESENT, ACTIVE, QUAL_ABSENT} st_t;

  st_t             state;
  logic [CNT_W-1:0] cnt;
  logic [SW-1:0]    sdly;

  wire pres_done = (cnt >= present_guard - CNT_W'(1));
  wire abs_done  = (cnt >= absent_guard - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      cnt         <= '0;
      sdly        <= '0;
      rx_code     <= '0;
      digit_valid <= 1'b0;
      rx_full     <= 1'b0;
    end else begin
      rx_full <= 1'b0;
      if (sdly != '0) begin
        sdly <= sdly - SW'(1);
        if (sdly == SW'(1)) begin
          digit_valid <= 1'b1;
          rx_full     <= 1'b1;
        end
      end
      if (cp_mode) begin
        state       <= IDLE;
        cnt         <= '0;
        sdly        <= '0;
        digit_valid <= 1'b0;
        rx_full     <= 1'b0;
      end else begin
        unique case (state)
          IDLE: if (est) begin
            state <= QUAL_PRESENT;
            cnt   <= CNT_W'(1);
          end
          QUAL_PRESENT: begin
            if (!est) begin
              state <= IDLE;
              cnt   <= '0;
            end else if (pres_done) begin
              rx_code <= code_in;
              state   <= ACTIVE;
              sdly    <= SW'(SETTLE);
              cnt     <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ACTIVE: if (!est) begin
            state <= QUAL_ABSENT;
            cnt   <= CNT_W'(1);
          end
          QUAL_ABSENT: begin
            if (est) begin
              state <= ACTIVE;
              cnt   <= '0;
            end else if (abs_done) begin
              state       <= IDLE;
              digit_valid <= 1'b0;
              cnt         <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  // R5: strobe is a single cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> !rx_full);

  // R5: flag rise coincides with strobe
  a_r5_rise_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digit_valid) |-> rx_full);

  // R8: call-progress mode clears flag and strobe
  a_r8_cp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cp_mode |=> (!digit_valid && !rx_full));

  // R2: receive register moves only out of qualification with tone present
  a_r2_code_update: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_code) |-> ($past(state) == QUAL_PRESENT && $past(est) && !$past(cp_mode)));

  // R6: flag drops only on absence or call-progress mode
  a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(digit_valid) |-> ($past(cp_mode) || !$past(est)));
endmodule

// File: tb/tb_tone_guard_timer.sv
module tb_tone_guard_timer;
  localparam int CNT_W  = 24;
  localparam int SETTLE = 2;
  localparam int PG = 5;
  localparam int AG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp_mode = 1'b0;
  logic est = 1'b0;
  logic [3:0] code_in = 4'd0;
  logic [CNT_W-1:0] present_guard = CNT_W'(PG);
  logic [CNT_W-1:0] absent_guard  = CNT_W'(AG);
  logic [3:0] rx_code;
  logic digit_valid, rx_full;

  always #10 clk = ~clk;

  tone_guard_timer #(.CNT_W(CNT_W), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .cp_mode(cp_mode), .est(est), .code_in(code_in),
    .present_guard(present_guard), .absent_guard(absent_guard),
    .rx_code(rx_code), .digit_valid(digit_valid), .rx_full(rx_full));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strobes = 0;
  bit done = 1'b0;

  int hi_run = 0, lo_run = 0, settle_at = -1;
  bit holding = 1'b0;
  logic [3:0] m_code = 4'd0;
  logic m_valid = 1'b0, m_full = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; holding = 0; settle_at = -1;
      m_code = 0; m_valid = 0; m_full = 0;
    end else begin
      m_full = 0;
      if (settle_at == cyc) begin m_valid = 1; m_full = 1; settle_at = -1; end
      if (cp_mode) begin
        hi_run = 0; lo_run = 0; holding = 0; settle_at = -1;
        m_valid = 0; m_full = 0;
      end else begin
        if (est) begin hi_run++; lo_run = 0; end
        else begin lo_run++; hi_run = 0; end
        if (!holding && est && hi_run >= PG) begin
          m_code = code_in; holding = 1; settle_at = cyc + SETTLE;
        end else if (holding && !est && lo_run >= AG) begin
          holding = 0; m_valid = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_full) strobes++;
    chk("R2 rx_code vs model", rx_code, m_code);
    chk("R6 digit_valid vs model", digit_valid, m_valid);
    chk("R5 rx_full vs model", rx_full, m_full);
  end

  task automatic drive(input bit e, input logic [3:0] c, input bit p, input int n);
    est = e; code_in = c; cp_mode = p;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset rx_code", rx_code, 0);
    chk("R1 reset digit_valid", digit_valid, 0);
    chk("R1 reset rx_full", rx_full, 0);
    rst_n = 1'b1;
    drive(0, 4'd0, 0, 3);

    drive(1, 4'd7, 0, PG - 1);
    drive(0, 4'd7, 0, AG + 4);
    chk("R3 short burst rx_code", rx_code, 0);
    chk("R3 short burst strobes", strobes, 0);

    s0 = strobes;
    drive(1, 4'd5, 0, PG + SETTLE + 2);
    chk("R2 registered code", rx_code, 5);
    chk("R5 one strobe", strobes - s0, 1);
    chk("R5 flag high", digit_valid, 1);
    drive(1, 4'd9, 0, 6);
    chk("R4 code ignored while held", rx_code, 5);

    drive(0, 4'd9, 0, AG - 1);
    drive(1, 4'd9, 0, PG + 3);
    chk("R7 drop-out code", rx_code, 5);
    chk("R7 drop-out flag", digit_valid, 1);
    chk("R7 drop-out no extra strobe", strobes - s0, 1);

    drive(0, 4'd9, 0, AG);
    chk("R6 pause flag low", digit_valid, 0);
    chk("R6 code retained", rx_code, 5);

    drive(1, 4'd12, 1, PG + 6);
    chk("R8 cp no register", rx_code, 5);
    chk("R8 cp flag low", digit_valid, 0);
    drive(1, 4'd12, 0, PG - 1);
    chk("R8 full guard after cp", rx_code, 5);
    drive(1, 4'd12, 0, 1 + SETTLE);
    chk("R8 register after cp", rx_code, 12);
    drive(0, 4'd0, 0, AG + 2);

    s0 = strobes;
    drive(1, 4'd3, 0, PG);
    drive(1, 4'd3, 1, 1);
    drive(0, 4'd3, 0, SETTLE + 2);
    chk("R8 pending strobe cancelled", strobes - s0, 0);
    chk("R8 code kept", rx_code, 3);

    for (int i = 0; i < 400; i++) begin
      drive($urandom % 2, 4'($urandom), ($urandom % 16) == 0, 1 + $urandom % 9);
    end
    drive(0, 4'd0, 0, AG + SETTLE + 2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule